// File: doc/BRIEF.md
# Burst SRAM Read Sequencer

This block is a small clocked controller that walks a synchronous burst SRAM through a single burst read. A requester holds `go` high and supplies a 16-bit starting address. The sequencer then steps through four phases: idle, address, hold and beat. It drives two active-low address strobes, an active-low burst-advance line and an active-low output enable for the memory.

The starting address goes onto the shared address bus for exactly one phase. In every other phase the address pads are released. Once the beat phase is reached, the memory's 32-bit read data is valid. It is passed to `rd_data` with `rd_valid` high. While `go` stays high, the sequencer remains in the beat phase and asserts advance every cycle, so the memory steps to its next burst location on each cycle. Dropping `go` ends the burst from any phase on the next clock edge.

The chip selects are tied active. The write enable is held inactive.

Top module: `burst_sram_reader`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after it, all of the following hold: `ads_cpu_n`, `ads_ctl_n`, `adv_n` and `mem_oe_n` are 1; `addr_oe` is 0; `rd_valid` is 0.
- R2: In the idle phase with `go` at 0, the next cycle is again idle. Idle means: both strobes 1, `adv_n` 1, `mem_oe_n` 1, `addr_oe` 0.
- R3: From idle, `go` at 1 on a clock edge enters the address phase for the next cycle. In the address phase `ads_cpu_n`=0, `ads_ctl_n`=0, `adv_n`=0 and `mem_oe_n`=1. `addr_oe`=1, and `sram_addr` carries the `start_addr` value sampled on that edge.
- R4: From the address phase, `go` at 1 enters the hold phase. In the hold phase `ads_cpu_n`=1, `ads_ctl_n`=0, `adv_n`=1, `mem_oe_n`=1 and `addr_oe`=0.
- R5: From the hold phase, `go` at 1 enters the beat phase. In the beat phase `ads_cpu_n`=1, `ads_ctl_n`=1, `adv_n`=0 and `mem_oe_n`=0. `rd_valid` is 1 and `rd_data` equals `sram_data` in that cycle.
- R6: In the beat phase with `go` at 1, the sequencer stays in the beat phase. `rd_valid` and the advance line are asserted on every such cycle.
- R7: `go` at 0 on any clock edge returns the sequencer to idle for the next cycle, whichever phase it was in.
- R8: `addr_oe` is 1 only in the address phase. A change of `start_addr` outside the edge that leaves idle does not alter the address driven in that phase.
- R9: `cs_a_n` and `cs_b_n` are always 0, `cs_c` is always 1 and `mem_we_n` is always 1.
- R10: `rd_data` is all zeros whenever `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Burst enable; 0 aborts |
| start_addr | input | 16 | First address of the burst |
| sram_data | input | 32 | Read data from memory |
| sram_addr | output | 16 | Address pads, released when not driven |
| addr_oe | output | 1 | High when `sram_addr` is driven |
| ads_cpu_n | output | 1 | Processor-side address strobe, active low |
| ads_ctl_n | output | 1 | Controller-side address strobe, active low |
| adv_n | output | 1 | Burst advance, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Write enable, held high |
| cs_a_n | output | 1 | Chip select, held low |
| cs_b_n | output | 1 | Chip select, held low |
| cs_c | output | 1 | Chip select, held high |
| rd_data | output | 32 | Captured read data |
| rd_valid | output | 1 | High in each beat cycle |

## Verification
The assertions run on every cycle and cover the following:
- the order of the strobe patterns: address phase, then hold, then beat;
- the return to the idle pattern one edge after `go` falls;
- that the address pads are released whenever the address-phase strobe pattern is absent;
- the link between `rd_valid` and the output enable;
- the constant chip-select and write-enable levels.

Other properties need the bench's own reference model and scenarios:
- that the driven address is the value sampled when idle was left;
- that `rd_data` follows the memory bus;
- that aborts work from each phase;
- that long beat runs keep advancing.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_HOLD = 2'd2,
    PH_BEAT = 2'd3
  } phase_t;

  typedef struct packed {
    logic ads_cpu_n;
    logic ads_ctl_n;
    logic adv_n;
    logic oe_n;
    logic addr_en;
  } strobe_t;

  // Pin levels for each phase.
  function automatic strobe_t phase_strobes(input phase_t ph);
    strobe_t s;
    case (ph)
      PH_ADDR: s = '{ads_cpu_n: 1'b0, ads_ctl_n: 1'b0, adv_n: 1'b0, oe_n: 1'b1, addr_en: 1'b1};
      PH_HOLD: s = '{ads_cpu_n: 1'b1, ads_ctl_n: 1'b0, adv_n: 1'b1, oe_n: 1'b1, addr_en: 1'b0};
      PH_BEAT: s = '{ads_cpu_n: 1'b1, ads_ctl_n: 1'b1, adv_n: 1'b0, oe_n: 1'b0, addr_en: 1'b0};
      default: s = '{ads_cpu_n: 1'b1, ads_ctl_n: 1'b1, adv_n: 1'b1, oe_n: 1'b1, addr_en: 1'b0};
    endcase
    return s;
  endfunction

  // Next phase: a low enable always returns to idle; beat is terminal while enabled.
  function automatic phase_t phase_next(input phase_t ph, input logic en);
    phase_t n;
    if (!en) begin
      n = PH_IDLE;
    end else begin
      case (ph)
        PH_IDLE: n = PH_ADDR;
        PH_ADDR: n = PH_HOLD;
        PH_HOLD: n = PH_BEAT;
        default: n = PH_BEAT;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/bsr_phase_fsm.sv
module bsr_phase_fsm
  import bsr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   go,
  output phase_t phase,
  output logic   leave_idle
);

  phase_t phase_q;
  phase_t phase_d;

  always_comb begin
    phase_d = phase_next(phase_q, go);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase      = phase_q;
  assign leave_idle = (phase_q == PH_IDLE) && go && !rst;

endmodule

// File: rtl/bsr_strobe_dec.sv
module bsr_strobe_dec
  import bsr_pkg::*;
(
  input  phase_t phase,
  output logic   ads_cpu_n,
  output logic   ads_ctl_n,
  output logic   adv_n,
  output logic   oe_n,
  output logic   addr_en,
  output logic   beat
);

  strobe_t s;

  always_comb begin
    s = phase_strobes(phase);
  end

  assign ads_cpu_n = s.ads_cpu_n;
  assign ads_ctl_n = s.ads_ctl_n;
  assign adv_n     = s.adv_n;
  assign oe_n      = s.oe_n;
  assign addr_en   = s.addr_en;
  assign beat      = (phase == PH_BEAT);

endmodule

// File: rtl/bsr_data_path.sv
module bsr_data_path #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              addr_en,
  input  logic              beat,
  input  logic [DATA_W-1:0] sram_data,
  output wire  [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [ADDR_W-1:0] ADDR_FLOAT = {ADDR_W{1'bz}};

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (capture) begin
      addr_q <= start_addr;
    end
  end

  assign sram_addr = addr_en ? addr_q : ADDR_FLOAT;
  assign rd_data   = beat ? sram_data : '0;

endmodule

// File: rtl/burst_sram_reader.sv
module burst_sram_reader
  import bsr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] sram_data,
  output wire  [ADDR_W-1:0] sram_addr,
  output logic              addr_oe,
  output logic              ads_cpu_n,
  output logic              ads_ctl_n,
  output logic              adv_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              cs_a_n,
  output logic              cs_b_n,
  output logic              cs_c,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  phase_t phase;
  logic   leave_idle;
  logic   addr_en;
  logic   beat;

  bsr_phase_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .phase      (phase),
    .leave_idle (leave_idle)
  );

  bsr_strobe_dec u_dec (
    .phase     (phase),
    .ads_cpu_n (ads_cpu_n),
    .ads_ctl_n (ads_ctl_n),
    .adv_n     (adv_n),
    .oe_n      (mem_oe_n),
    .addr_en   (addr_en),
    .beat      (beat)
  );

  bsr_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .capture    (leave_idle),
    .start_addr (start_addr),
    .addr_en    (addr_en),
    .beat       (beat),
    .sram_data  (sram_data),
    .sram_addr  (sram_addr),
    .rd_data    (rd_data)
  );

  assign addr_oe  = addr_en;
  assign rd_valid = beat;
  assign mem_we_n = 1'b1;
  assign cs_a_n   = 1'b0;
  assign cs_b_n   = 1'b0;
  assign cs_c     = 1'b1;

endmodule

// File: rtl/burst_sram_reader_chk.sv
module burst_sram_reader_chk (
  input logic clk,
  input logic rst,
  input logic go,
  input logic addr_oe,
  input logic ads_cpu_n,
  input logic ads_ctl_n,
  input logic adv_n,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic cs_a_n,
  input logic cs_b_n,
  input logic cs_c,
  input logic rd_valid
);

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (ads_cpu_n && ads_ctl_n && adv_n && mem_oe_n && !addr_oe && !rd_valid)); // R1

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst) !go |=> (ads_cpu_n && ads_ctl_n && adv_n && mem_oe_n && !addr_oe)); // R7

  AST_ADDR_THEN_HOLD: assert property (@(posedge clk) disable iff (rst) (!ads_cpu_n && go) |=> (ads_cpu_n && !ads_ctl_n && adv_n && mem_oe_n)); // R4

  AST_HOLD_THEN_BEAT: assert property (@(posedge clk) disable iff (rst) (ads_cpu_n && !ads_ctl_n && go) |=> (!mem_oe_n && !adv_n && rd_valid)); // R5

  AST_BEAT_STAYS: assert property (@(posedge clk) disable iff (rst) (rd_valid && go) |=> (rd_valid && !adv_n)); // R6

  AST_IDLE_TO_ADDR: assert property (@(posedge clk) disable iff (rst) (ads_ctl_n && !rd_valid && go) |=> (addr_oe && !ads_cpu_n && !ads_ctl_n && mem_oe_n)); // R3

  AST_ADDR_PADS_ONLY: assert property (@(posedge clk) disable iff (rst) addr_oe |-> (!ads_cpu_n && !ads_ctl_n)); // R8

  AST_VALID_WITH_OE: assert property (@(posedge clk) disable iff (rst) rd_valid == !mem_oe_n); // R5

  AST_FIXED_PINS: assert property (@(posedge clk) disable iff (rst) (mem_we_n && !cs_a_n && !cs_b_n && cs_c)); // R9

endmodule

bind burst_sram_reader burst_sram_reader_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .go        (go),
  .addr_oe   (addr_oe),
  .ads_cpu_n (ads_cpu_n),
  .ads_ctl_n (ads_ctl_n),
  .adv_n     (adv_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .cs_a_n    (cs_a_n),
  .cs_b_n    (cs_b_n),
  .cs_c      (cs_c),
  .rd_valid  (rd_valid)
);

// File: tb/burst_sram_reader_tb.sv
`timescale 1ns/1ps
module burst_sram_reader_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        go = 1'b0;
  logic [15:0] start_addr = '0;
  logic [31:0] sram_data = '0;
  wire  [15:0] sram_addr;
  logic        addr_oe, ads_cpu_n, ads_ctl_n, adv_n, mem_oe_n, mem_we_n;
  logic        cs_a_n, cs_b_n, cs_c, rd_valid;
  logic [31:0] rd_data;

  int checks = 0;
  int fails = 0;
  int st = 0;
  int prev_st = 0;
  logic [15:0] held_addr = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_sram_reader u_dut (
    .clk(clk), .rst(rst), .go(go), .start_addr(start_addr), .sram_data(sram_data),
    .sram_addr(sram_addr), .addr_oe(addr_oe), .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n),
    .adv_n(adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .cs_a_n(cs_a_n),
    .cs_b_n(cs_b_n), .cs_c(cs_c), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // Expected {ads_cpu_n, ads_ctl_n, adv_n, mem_oe_n, addr_oe, rd_valid} per model phase.
  function automatic logic [5:0] want_pins(input int ph);
    case (ph)
      1: return 6'b000110;
      2: return 6'b101100;
      3: return 6'b110001;
      default: return 6'b111100;
    endcase
  endfunction

  function automatic string tag_for(input int ph, input int pv);
    if (ph == 0) return (pv == 0) ? "R2" : "R7";
    if (ph == 1) return "R3";
    if (ph == 2) return "R4";
    return (pv == 3) ? "R6" : "R5";
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_outputs();
    logic [5:0] got;
    got = {ads_cpu_n, ads_ctl_n, adv_n, mem_oe_n, addr_oe, rd_valid};
    chk(tag_for(st, prev_st), {26'd0, got}, {26'd0, want_pins(st)});
    if (st == 1) chk("R8", {16'd0, sram_addr}, {16'd0, held_addr});
    if (st == 3) chk("R5", rd_data, sram_data);
    else chk("R10", rd_data, 32'd0);
    chk("R9", {28'd0, mem_we_n, cs_a_n, cs_b_n, cs_c}, 32'h9);
  endtask

  // One cycle: inputs set at the falling edge, model stepped at the rising edge, outputs checked 1 ns later.
  task automatic step(input logic g, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    go = g;
    start_addr = a;
    sram_data = d;
    @(posedge clk);
    prev_st = st;
    if (rst) st = 0;
    else if (!g) st = 0;
    else begin
      if (st == 0) held_addr = a;
      st = (st == 3) ? 3 : st + 1;
    end
    #1;
    if (!rst) check_outputs();
  endtask

  initial begin
    #(5 * 190000);
    $display("FAIL watchdog actual=running expected=finished");
    fails++;
    checks++;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset holds idle even with go high
    step(1'b1, 16'hAAAA, 32'h1);
    step(1'b1, 16'hAAAA, 32'h2);
    #1;
    chk("R1", {26'd0, ads_cpu_n, ads_ctl_n, adv_n, mem_oe_n, addr_oe, rd_valid}, {26'd0, 6'b111100});
    @(negedge clk);
    rst = 1'b0;
    st = 0;
    step(1'b0, 16'h0, 32'h0);                           // R2 stays idle
    // full burst, address changed during later phases (R8)
    step(1'b1, 16'h1234, 32'h11111111);                // R3
    step(1'b1, 16'hFFFF, 32'h22222222);                // R4
    step(1'b1, 16'h0F0F, 32'h33333333);                // R5
    for (int i = 0; i < 5; i++) step(1'b1, 16'h5555, 32'hC0DE0000 + i); // R6
    step(1'b0, 16'h0, 32'h0);                           // R7 abort from beat
    // abort from address phase and from hold phase (R7)
    step(1'b1, 16'h00FF, 32'h0);
    step(1'b0, 16'h0, 32'h0);
    step(1'b1, 16'hFF00, 32'h0);
    step(1'b1, 16'h0, 32'h0);
    step(1'b0, 16'h0, 32'h0);
    // boundary addresses
    step(1'b1, 16'h0000, 32'h0);
    step(1'b0, 16'h0, 32'h0);
    step(1'b1, 16'hFFFF, 32'h0);
    step(1'b0, 16'h0, 32'h0);
    // constrained random: go high most of the time
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 8) != 0, 16'($urandom), $urandom);
    end
    // reset in the middle of a beat run (R1)
    step(1'b1, 16'h4321, 32'h0);
    step(1'b1, 16'h0, 32'h0);
    step(1'b1, 16'h0, 32'h0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    st = 0;
    #1;
    chk("R1", {26'd0, ads_cpu_n, ads_ctl_n, adv_n, mem_oe_n, addr_oe, rd_valid}, {26'd0, 6'b111100});
    chk("R10", rd_data, 32'd0);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule